// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block turns a handful of host-written registers into the pin-level cycles of a parallel NAND flash device on chip enable 0. The host loads a first opcode, an optional second opcode and a 64-bit address image split over two words. It then writes a command word. That word chooses which phases run: opcode latch, address latch (with a programmable byte count), second opcode latch and a programmed-I/O receive of one to four bytes. The start bit in the same word launches the sequence.

The phases always run in a fixed order. First the opcode latch, then the address bytes, least significant first. Next comes the second opcode, then a wait for the device to go busy and return to ready, and last the data reads. The received bytes are packed into a 32-bit response word. When the sequence ends, the start bit reads back clear and a sticky done flag is raised. Typical uses are an identify read (opcode, one address byte, four data bytes), a status poll (opcode, one data byte), a device reset (opcode only), an erase (opcode, three row bytes, confirm opcode) and a page-open read (opcode, five address bytes, confirm, then data).

Top module: `nand_seq`

## Requirements
- R1: Writing register 0 with bit 31 set starts a command. Bit 31 of register 0 reads 1 while the command runs and 0 once it has ended. After reset, registers 0, 6 and 7 read 0, chip enable is high and both strobes are high.
- R2: When command-word bit 30 is set, the byte in register 1 is driven with CLE high for one write strobe. When bit 30 is clear, no opcode strobe is issued.
- R3: When bit 29 is set, the count in bits 18:16 sets how many address bytes are driven with ALE high. Byte k is bits 8k+7:8k of {register 4, register 3}, so the column sits in register 3 bits 15:0 and the low row bits in register 3 bits 31:16. A count of zero issues no address byte.
- R4: When bit 28 is set, the byte in register 2 is driven with CLE high after the address bytes.
- R5: After the second opcode, no read strobe is issued until the ready line has gone low and then high again. Each of those two waits gives up after BUSY_TIMEOUT cycles, and the sequence then goes on.
- R6: When bit 27 is set, bits 1:0 plus one bytes are read. Byte k lands in bits 8k+7:8k of register 7, and bytes not read are 0.
- R7: Register 5 bit 0 follows the ready line (1 = ready), after a two-stage synchronizer.
- R8: Register 6 bit 0 and the done_irq output are set when a command ends. Writing 1 to that bit clears it, and writing 0 leaves it unchanged.
- R9: While a command runs, writes to registers 0 to 4 are ignored, including a second start.
- R10: Each write strobe holds WE# low for T_WE_LO cycles and then high for at least T_WE_HI cycles. Each read strobe holds RE# low for T_RE_LO cycles.
- R11: Chip enable is low exactly while a command runs. CLE and ALE are never high together, and no strobe occurs while chip enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| bus_wr | input | 1 | register write strobe |
| bus_addr | input | 3 | register word index |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data (combinational) |
| done_irq | output | 1 | sticky command-done flag |
| nand_ce_n | output | 1 | chip enable 0, active low |
| nand_cle | output | 1 | command latch enable |
| nand_ale | output | 1 | address latch enable |
| nand_we_n | output | 1 | write strobe |
| nand_re_n | output | 1 | read strobe |
| nand_io_out | output | 8 | byte driven to the device |
| nand_io_oe | output | 1 | output enable for nand_io_out |
| nand_io_in | input | 8 | byte from the device |
| nand_rb | input | 1 | ready/busy line, 1 = ready |

## Verification
A table of five command words is run against a behavioural device model, and each entry uses a different phase set. An identify read (four bytes), a status poll (one byte), a reset (opcode only), a page-open read and an erase together separate phase skipping, address-count handling, the packing of the response and byte lanes left empty. The page read with its confirm opcode makes the model go busy, which shows whether reads wait for the ready line. A stuck-busy device tests the timeout path. Directed cases cover a start written during a command, clearing of the done flag, a zero address count and a command with the opcode phase turned off.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam logic [2:0] RA_CMD  = 3'd0;
  localparam logic [2:0] RA_OP1  = 3'd1;
  localparam logic [2:0] RA_OP2  = 3'd2;
  localparam logic [2:0] RA_ALO  = 3'd3;
  localparam logic [2:0] RA_AHI  = 3'd4;
  localparam logic [2:0] RA_STAT = 3'd5;
  localparam logic [2:0] RA_IRQ  = 3'd6;
  localparam logic [2:0] RA_RESP = 3'd7;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CMD1, PH_ADDR, PH_CMD2, PH_WLO, PH_WHI, PH_DATA, PH_FIN
  } phase_e;

  typedef struct packed {
    logic       cle_en;
    logic       ale_en;
    logic       sec_en;
    logic       rx_en;
    logic [2:0] nadr;
    logic [1:0] xsz;
  } cmd_t;

  function automatic cmd_t unpack_cmd(input logic [31:0] w);
    cmd_t c;
    c.cle_en = w[30];
    c.ale_en = w[29];
    c.sec_en = w[28];
    c.rx_en  = w[27];
    c.nadr   = w[18:16];
    c.xsz    = w[1:0];
    return c;
  endfunction

  function automatic logic [31:0] pack_cmd(input logic go, input cmd_t c);
    logic [31:0] w;
    w = '0;
    w[31] = go;
    w[30] = c.cle_en;
    w[29] = c.ale_en;
    w[28] = c.sec_en;
    w[27] = c.rx_en;
    w[18:16] = c.nadr;
    w[1:0] = c.xsz;
    return w;
  endfunction

  // byte k of the 64-bit address image, low word first
  function automatic logic [7:0] addr_byte(input logic [31:0] lo, input logic [31:0] hi,
                                           input logic [2:0] k);
    logic [63:0] img;
    img = {hi, lo};
    return img[{k, 3'b000} +: 8];
  endfunction

  function automatic logic [31:0] put_byte(input logic [31:0] r, input logic [1:0] k,
                                           input logic [7:0] b);
    logic [31:0] o;
    o = r;
    o[{k, 3'b000} +: 8] = b;
    return o;
  endfunction

endpackage

// File: rtl/nand_seq_strobe.sv
module nand_seq_strobe #(
  parameter int unsigned T_WE_LO = 3,
  parameter int unsigned T_WE_HI = 2,
  parameter int unsigned T_RE_LO = 3,
  parameter int unsigned T_RE_HI = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rd,
  output logic idle,
  output logic done,
  output logic sample,
  output logic we_n,
  output logic re_n
);
  localparam int unsigned MAX_W = (T_WE_LO > T_WE_HI) ? T_WE_LO : T_WE_HI;
  localparam int unsigned MAX_R = (T_RE_LO > T_RE_HI) ? T_RE_LO : T_RE_HI;
  localparam int unsigned MAX_T = (MAX_W > MAX_R) ? MAX_W : MAX_R;
  localparam int unsigned CW    = $clog2(MAX_T + 1);

  typedef enum logic [1:0] {SB_IDLE, SB_LO, SB_HI} sb_e;

  sb_e           st;
  logic [CW-1:0] cnt;
  logic          rd_q;
  logic          cnt_zero;

  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= SB_IDLE;
      cnt  <= '0;
      rd_q <= 1'b0;
    end else begin
      case (st)
        SB_IDLE: if (start) begin
          st   <= SB_LO;
          rd_q <= rd;
          cnt  <= rd ? CW'(T_RE_LO - 1) : CW'(T_WE_LO - 1);
        end
        SB_LO: if (cnt_zero) begin
          st  <= SB_HI;
          cnt <= rd_q ? CW'(T_RE_HI - 1) : CW'(T_WE_HI - 1);
        end else cnt <= cnt - 1'b1;
        SB_HI: if (cnt_zero) st <= SB_IDLE;
               else cnt <= cnt - 1'b1;
        default: st <= SB_IDLE;
      endcase
    end
  end

  assign idle   = (st == SB_IDLE);
  assign done   = (st == SB_HI) && cnt_zero;
  assign sample = (st == SB_LO) && cnt_zero && rd_q;
  assign we_n   = !((st == SB_LO) && !rd_q);
  assign re_n   = !((st == SB_LO) && rd_q);

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> idle); // R10
  AST_LO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && !cnt_zero) |=> !we_n); // R10

endmodule

// File: rtl/nand_seq_regs.sv
module nand_seq_regs
  import nand_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        busy,
  input  logic        done_pulse,
  input  logic        ready,
  input  logic        resp_we,
  input  logic [1:0]  resp_idx,
  input  logic [7:0]  resp_byte,
  output logic        go_pulse,
  output cmd_t        cmd,
  output logic [7:0]  op1,
  output logic [7:0]  op2,
  output logic [31:0] adr_lo,
  output logic [31:0] adr_hi,
  output logic        irq
);
  logic        cfg_wr;
  logic [31:0] resp_q;
  logic        irq_clr;

  assign cfg_wr   = bus_wr && !busy;
  assign go_pulse = cfg_wr && (bus_addr == RA_CMD) && bus_wdata[31];
  assign irq_clr  = bus_wr && (bus_addr == RA_IRQ) && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd    <= '0;
      op1    <= '0;
      op2    <= '0;
      adr_lo <= '0;
      adr_hi <= '0;
    end else if (cfg_wr) begin
      case (bus_addr)
        RA_CMD: cmd    <= unpack_cmd(bus_wdata);
        RA_OP1: op1    <= bus_wdata[7:0];
        RA_OP2: op2    <= bus_wdata[7:0];
        RA_ALO: adr_lo <= bus_wdata;
        RA_AHI: adr_hi <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resp_q <= '0;
    else if (go_pulse) resp_q <= '0;
    else if (resp_we) resp_q <= put_byte(resp_q, resp_idx, resp_byte);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else if (done_pulse) irq <= 1'b1;
    else if (irq_clr) irq <= 1'b0;
  end

  always_comb begin
    case (bus_addr)
      RA_CMD:  bus_rdata = pack_cmd(busy, cmd);
      RA_OP1:  bus_rdata = {24'b0, op1};
      RA_OP2:  bus_rdata = {24'b0, op2};
      RA_ALO:  bus_rdata = adr_lo;
      RA_AHI:  bus_rdata = adr_hi;
      RA_STAT: bus_rdata = {31'b0, ready};
      RA_IRQ:  bus_rdata = {31'b0, irq};
      default: bus_rdata = resp_q;
    endcase
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(cmd) && $stable(adr_lo) && $stable(adr_hi) && $stable(op1))); // R9
  AST_IRQ_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !done_pulse) |=> !irq); // R8
  AST_IRQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> irq); // R8

endmodule

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int unsigned BUSY_TIMEOUT = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  cmd_t        cmd,
  input  logic [7:0]  op1,
  input  logic [7:0]  op2,
  input  logic [31:0] adr_lo,
  input  logic [31:0] adr_hi,
  input  logic        ready,
  input  logic [7:0]  io_in,
  input  logic        s_idle,
  input  logic        s_done,
  input  logic        s_sample,
  output logic        s_start,
  output logic        s_rd,
  output logic        running,
  output logic        done_pulse,
  output logic        resp_we,
  output logic [1:0]  resp_idx,
  output logic [7:0]  resp_byte,
  output logic        cle,
  output logic        ale,
  output logic [7:0]  io_out,
  output logic        io_oe
);
  localparam int unsigned TW = $clog2(BUSY_TIMEOUT + 1);

  phase_e        ph;
  logic          launched;
  logic [2:0]    idx;
  logic [TW-1:0] tmo;
  logic          tmo_hit;

  assign tmo_hit = (tmo == TW'(BUSY_TIMEOUT - 1));

  function automatic phase_e after_wait(input cmd_t c);
    return c.rx_en ? PH_DATA : PH_FIN;
  endfunction

  function automatic phase_e after_addr(input cmd_t c);
    return c.sec_en ? PH_CMD2 : after_wait(c);
  endfunction

  function automatic phase_e after_cmd1(input cmd_t c);
    return (c.ale_en && (c.nadr != 3'd0)) ? PH_ADDR : after_addr(c);
  endfunction

  assign s_start = !launched && s_idle &&
                   (((ph == PH_CMD1) && cmd.cle_en) || (ph == PH_ADDR) ||
                    (ph == PH_CMD2) || (ph == PH_DATA));
  assign s_rd = (ph == PH_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      launched <= 1'b0;
      idx      <= '0;
      tmo      <= '0;
    end else begin
      if (s_start) launched <= 1'b1;
      else if (s_done) launched <= 1'b0;
      case (ph)
        PH_IDLE: if (go) begin
          ph  <= PH_CMD1;
          idx <= '0;
        end
        PH_CMD1: if (!cmd.cle_en || s_done) ph <= after_cmd1(cmd);
        PH_ADDR: if (s_done) begin
          if (idx == cmd.nadr - 3'd1) begin
            idx <= '0;
            ph  <= after_addr(cmd);
          end else idx <= idx + 3'd1;
        end
        PH_CMD2: if (s_done) begin
          ph  <= PH_WLO;
          tmo <= '0;
        end
        PH_WLO: begin
          if (!ready) begin
            ph  <= PH_WHI;
            tmo <= '0;
          end else if (tmo_hit) ph <= after_wait(cmd);
          else tmo <= tmo + 1'b1;
        end
        PH_WHI: begin
          if (ready || tmo_hit) ph <= after_wait(cmd);
          else tmo <= tmo + 1'b1;
        end
        PH_DATA: if (s_done) begin
          if (idx[1:0] == cmd.xsz) begin
            idx <= '0;
            ph  <= PH_FIN;
          end else idx <= idx + 3'd1;
        end
        PH_FIN: ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign running    = (ph != PH_IDLE);
  assign done_pulse = (ph == PH_FIN);
  assign resp_we    = s_sample;
  assign resp_idx   = idx[1:0];
  assign resp_byte  = io_in;
  assign cle        = ((ph == PH_CMD1) && cmd.cle_en) || (ph == PH_CMD2);
  assign ale        = (ph == PH_ADDR);
  assign io_oe      = cle || ale;

  always_comb begin
    case (ph)
      PH_CMD1: io_out = op1;
      PH_CMD2: io_out = op2;
      PH_ADDR: io_out = addr_byte(adr_lo, adr_hi, idx);
      default: io_out = 8'h00;
    endcase
  end

  AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale)); // R11
  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_IDLE) |-> s_idle); // R11
  AST_DONE_CLEARS_GO: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !running); // R1
  AST_SAMPLE_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    s_sample |-> (ph == PH_DATA)); // R6

endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nand_seq_pkg::*;
#(
  parameter int unsigned T_WE_LO      = 3,
  parameter int unsigned T_WE_HI      = 2,
  parameter int unsigned T_RE_LO      = 3,
  parameter int unsigned T_RE_HI      = 2,
  parameter int unsigned BUSY_TIMEOUT = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        done_irq,
  output logic        nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic [7:0]  nand_io_out,
  output logic        nand_io_oe,
  input  logic [7:0]  nand_io_in,
  input  logic        nand_rb
);
  logic [1:0]  rb_sync;
  logic        ready;
  logic        go_pulse, busy, done_pulse;
  logic        resp_we;
  logic [1:0]  resp_idx;
  logic [7:0]  resp_byte;
  cmd_t        cmd;
  logic [7:0]  op1, op2;
  logic [31:0] adr_lo, adr_hi;
  logic        s_start, s_rd, s_idle, s_done, s_sample;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rb_sync <= 2'b00;
    else rb_sync <= {rb_sync[0], nand_rb};
  end
  assign ready = rb_sync[1];

  nand_seq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
    .done_pulse(done_pulse), .ready(ready), .resp_we(resp_we),
    .resp_idx(resp_idx), .resp_byte(resp_byte), .go_pulse(go_pulse),
    .cmd(cmd), .op1(op1), .op2(op2), .adr_lo(adr_lo), .adr_hi(adr_hi),
    .irq(done_irq)
  );

  nand_seq_ctrl #(.BUSY_TIMEOUT(BUSY_TIMEOUT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .go(go_pulse), .cmd(cmd), .op1(op1), .op2(op2),
    .adr_lo(adr_lo), .adr_hi(adr_hi), .ready(ready), .io_in(nand_io_in),
    .s_idle(s_idle), .s_done(s_done), .s_sample(s_sample), .s_start(s_start),
    .s_rd(s_rd), .running(busy), .done_pulse(done_pulse), .resp_we(resp_we),
    .resp_idx(resp_idx), .resp_byte(resp_byte), .cle(nand_cle), .ale(nand_ale),
    .io_out(nand_io_out), .io_oe(nand_io_oe)
  );

  nand_seq_strobe #(
    .T_WE_LO(T_WE_LO), .T_WE_HI(T_WE_HI), .T_RE_LO(T_RE_LO), .T_RE_HI(T_RE_HI)
  ) u_strobe (
    .clk(clk), .rst_n(rst_n), .start(s_start), .rd(s_rd), .idle(s_idle),
    .done(s_done), .sample(s_sample), .we_n(nand_we_n), .re_n(nand_re_n)
  );

  assign nand_ce_n = !busy;

  AST_NO_STROBE_CE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    nand_ce_n |-> (nand_we_n && nand_re_n)); // R11

endmodule

// File: tb/nand_seq_bench.sv
module nand_seq_bench;
  localparam int unsigned TWL = 3, TWH = 2, TRL = 3, TRH = 2, TMO = 200;

  typedef struct packed {
    logic [31:0] cmdw;
    logic [7:0]  op1;
    logic [7:0]  op2;
    logic [31:0] lo;
    logic [31:0] hi;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{32'hE801_0003, 8'h90, 8'h00, 32'h0000_0000, 32'h0000_0000},  // identify
    '{32'hC800_0000, 8'h70, 8'h00, 32'h0000_0000, 32'h0000_0000},  // status
    '{32'hC000_0000, 8'hFF, 8'h00, 32'h0000_0000, 32'h0000_0000},  // reset
    '{32'hF805_0001, 8'h00, 8'h30, 32'h1234_0056, 32'h0000_0078},  // page read
    '{32'hF003_0000, 8'h60, 8'hD0, 32'h00AB_CDEF, 32'h0000_0000}   // erase
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        done_irq, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [7:0]  nand_io_out, nand_io_in;
  logic        nand_rb;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  nand_seq #(.T_WE_LO(TWL), .T_WE_HI(TWH), .T_RE_LO(TRL), .T_RE_HI(TRH),
             .BUSY_TIMEOUT(TMO)) u_nand_seq (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done_irq(done_irq),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_io_out(nand_io_out),
    .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in), .nand_rb(nand_rb)
  );

  // device model, evaluated mid-cycle
  logic [7:0] cle_log [4];
  logic [7:0] ale_log [8];
  int ncle = 0, nale = 0, rdk = 0, busy_cnt = 0;
  int rd_busy = 0, viol = 0, wbad = 0, rbad = 0, whbad = 0, saw_busy = 0;
  int wlo_run = 0, rlo_run = 0, whi_run = 0;
  bit prev_we = 1, prev_re = 1, prev_ce = 1, stuck = 0;

  assign nand_rb = (busy_cnt == 0) && !stuck;
  assign nand_io_in = 8'hA0 + 8'(rdk);

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_ce && !nand_ce_n) begin
        ncle = 0; nale = 0; rdk = 0; rd_busy = 0; saw_busy = 0; whi_run = 0;
      end
      if (busy_cnt > 0) begin busy_cnt--; saw_busy = 1; end
      if (nand_ce_n && (!nand_we_n || !nand_re_n)) viol++;
      if (nand_cle && nand_ale) viol++;
      if (!nand_we_n) wlo_run++;
      if (!nand_re_n) rlo_run++;
      if (nand_we_n && !nand_ce_n) whi_run++;
      if (prev_we && !nand_we_n) begin
        if (ncle + nale > 0 && whi_run < TWH) whbad++;
      end
      if (!nand_we_n) whi_run = 0;
      if (!prev_we && nand_we_n) begin
        if (wlo_run != TWL) wbad++;
        wlo_run = 0;
        if (nand_cle && ncle < 4) begin
          cle_log[ncle] = nand_io_out; ncle++;
          if (nand_io_out == 8'h30 || nand_io_out == 8'hD0) busy_cnt = 20;
        end
        if (nand_ale && nale < 8) begin ale_log[nale] = nand_io_out; nale++; end
      end
      if (prev_re && !nand_re_n && !nand_rb) rd_busy++;
      if (!prev_re && nand_re_n) begin
        if (rlo_run != TRL) rbad++;
        rlo_run = 0;
        rdk++;
      end
      prev_we = nand_we_n; prev_re = nand_re_n; prev_ce = nand_ce_n;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle(output int cyc);
    logic [31:0] d;
    cyc = 0;
    do begin
      reg_rd(3'd0, d);
      cyc++;
    end while (d[31] && cyc < 5000);
  endtask

  task automatic load(input vec_t v);
    reg_wr(3'd1, {24'b0, v.op1});
    reg_wr(3'd2, {24'b0, v.op2});
    reg_wr(3'd3, v.lo);
    reg_wr(3'd4, v.hi);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, expw;
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: reset state
    reg_rd(3'd0, d); chk(d == 0, "R1 cmd after reset", d, 0);
    reg_rd(3'd6, d); chk(d == 0, "R8 irq after reset", d, 0);
    reg_rd(3'd7, d); chk(d == 0, "R6 resp after reset", d, 0);
    chk(nand_ce_n && nand_we_n && nand_re_n, "R11 pins idle after reset",
        {29'b0, nand_ce_n, nand_we_n, nand_re_n}, 32'h7);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [63:0] img;
      int exp_cle, exp_ale;
      v = VECS[i];
      reg_wr(3'd6, 32'h1);
      load(v);
      reg_wr(3'd0, v.cmdw);
      reg_rd(3'd0, d);
      chk(d[31], "R1 GO reads set while running", d, v.cmdw);
      chk(!nand_ce_n, "R11 CE low while running", {31'b0, nand_ce_n}, 0);
      wait_idle(cyc);
      reg_rd(3'd0, d);
      chk(d == (v.cmdw & 32'h7FFF_FFFF), "R1 GO clear after finish", d, v.cmdw & 32'h7FFF_FFFF);
      exp_cle = int'(v.cmdw[30]) + int'(v.cmdw[28]);
      chk(ncle == exp_cle, "R2 opcode strobe count", ncle, exp_cle);
      if (v.cmdw[30] && ncle > 0) chk(cle_log[0] == v.op1, "R2 first opcode", cle_log[0], v.op1);
      if (v.cmdw[28] && ncle == exp_cle) chk(cle_log[exp_cle-1] == v.op2, "R4 second opcode",
                                             cle_log[exp_cle-1], v.op2);
      exp_ale = v.cmdw[29] ? int'(v.cmdw[18:16]) : 0;
      chk(nale == exp_ale, "R3 address byte count", nale, exp_ale);
      img = {v.hi, v.lo};
      for (int k = 0; k < exp_ale && k < nale; k++)
        chk(ale_log[k] == img[8*k +: 8], "R3 address byte value", ale_log[k], img[8*k +: 8]);
      expw = 0;
      if (v.cmdw[27])
        for (int k = 0; k <= int'(v.cmdw[1:0]); k++) expw[8*k +: 8] = 8'hA0 + 8'(k);
      reg_rd(3'd7, d); chk(d == expw, "R6 response packing", d, expw);
      reg_rd(3'd6, d); chk(d == 1 && done_irq, "R8 done flag set", d, 1);
      if (v.cmdw[28] && v.cmdw[27]) begin
        chk(saw_busy == 1, "R5 device went busy", saw_busy, 1);
        chk(rd_busy == 0, "R5 no read while busy", rd_busy, 0);
      end
    end
    chk(viol == 0, "R11 strobe or CLE/ALE violation", viol, 0);
    chk(wbad == 0, "R10 WE low width", wbad, 0);
    chk(whbad == 0, "R10 WE high width", whbad, 0);
    chk(rbad == 0, "R10 RE low width", rbad, 0);

    // R8: write 0 keeps flag, write 1 clears
    reg_wr(3'd6, 32'h0);
    reg_rd(3'd6, d); chk(d == 1, "R8 write 0 ignored", d, 1);
    reg_wr(3'd6, 32'h1);
    reg_rd(3'd6, d); chk(d == 0 && !done_irq, "R8 write 1 clears", d, 0);

    // R9: writes while running ignored
    load(VECS[3]);
    reg_wr(3'd0, VECS[3].cmdw);
    reg_wr(3'd0, 32'hC800_0000);
    reg_wr(3'd3, 32'hDEAD_BEEF);
    wait_idle(cyc);
    reg_rd(3'd0, d); chk(d == 32'h7805_0001, "R9 cmd word kept", d, 32'h7805_0001);
    reg_rd(3'd3, d); chk(d == 32'h1234_0056, "R9 address kept", d, 32'h1234_0056);
    repeat (3) @(negedge clk);
    chk(nand_ce_n && ncle == 2, "R9 no second command", ncle, 2);

    // R7: ready status
    stuck = 1; repeat (4) @(negedge clk);
    reg_rd(3'd5, d); chk(d == 0, "R7 status busy", d, 0);
    stuck = 0; repeat (4) @(negedge clk);
    reg_rd(3'd5, d); chk(d == 1, "R7 status ready", d, 1);

    // R5: stuck busy times out
    reg_wr(3'd6, 32'h1);
    stuck = 1;
    reg_wr(3'd0, VECS[3].cmdw);
    wait_idle(cyc);
    stuck = 0;
    chk(cyc >= TMO && cyc < 1000, "R5 timeout then finish", cyc, TMO);
    reg_rd(3'd6, d); chk(d == 1, "R5 done after timeout", d, 1);

    // R3: zero address count
    reg_wr(3'd0, 32'hE000_0000);
    wait_idle(cyc);
    chk(nale == 0 && ncle == 1, "R3 zero count no address", nale, 0);

    // R2: opcode phase disabled
    reg_wr(3'd0, 32'hA002_0000);
    wait_idle(cyc);
    chk(ncle == 0, "R2 opcode skipped", ncle, 0);
    chk(nale == 2, "R3 two address bytes", nale, 2);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule